// File: doc/BRIEF.md
# Fixed-Interval Round-Robin Memory Arbiter

This block picks which of N requesters owns the next service cycle of a shared SDRAM. It does not wait for the current transaction to finish before choosing. The choice is made at a fixed point inside every service cycle, which is the end of the scheduling interval. That interval equals the shortest possible service cycle, so a decision is always ready when the current cycle ends, whatever the cycle's length.

A read cycle lasts `RD_LEN` clocks. A write cycle, which includes the read-to-write turnaround, lasts `WR_LEN` clocks. When nobody is requesting at the decision point, the arbiter runs an idle service cycle of `RD_LEN` clocks. It marks that cycle with `idle` so that a power-down controller can use the gap. A request that shows up after the decision point is not served in the next cycle. It is served at the decision point that follows.

Two inputs can hold off the start of the next cycle:
- A refresh-busy input.
- A wait-for-power-up input.

A choice already made is kept while either input holds the start.

Top module: `rr_slot_arb`

## Requirements
- R1: While reset is asserted, `grant` is 0, `idle` is 1 and `cyc_start` is 0. When reset is released, an idle service cycle of `RD_LEN` clocks begins.
- R2: `cyc_start` is high for exactly one clock, the first clock of each service cycle. `grant` is zero or one-hot. It changes only at a cycle start or when it drops to zero during a hold.
- R3: Requests are sampled only in clock `RD_LEN-1` of a service cycle, where the start clock is numbered 0. A request present in that clock can win the next cycle. A request first raised one clock later is not served in the next cycle.
- R4: The search for a winner starts at the pointer and proceeds in ascending index order, wrapping around. After a grant decision, the pointer moves to the index just above the winner, wrapping to 0. An idle decision leaves the pointer unchanged.
- R5: The winner's `req_wr` bit is sampled at the decision point (1 = write, 0 = read). A granted read cycle lasts `RD_LEN` clocks and a granted write cycle lasts `WR_LEN` clocks.
- R6: If no request is present at the decision point, the next cycle is idle. An idle cycle has `grant` = 0, `idle` = 1 and a length of `RD_LEN` clocks.
- R7: Suppose `ref_busy` is high in the last clock of a service cycle. Then the next cycle starts in the clock after the first clock in which `ref_busy` is low. During that hold, the pending choice does not change, even if new requests arrive.
- R8: `pup_wait` holds the next cycle start in the same way as `ref_busy`. If the hold ends before the last clock of the service cycle, the next start is not delayed.
- R9: When x requesters request without pause, each of them receives one service cycle out of every x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request line per requester |
| req_wr | input | N | Transaction type per requester (1 = write) |
| ref_busy | input | 1 | Refresh in progress; holds the next cycle start |
| pup_wait | input | 1 | Memory still powering up; holds the next cycle start |
| grant | output | N | One-hot owner of the current service cycle, 0 when idle |
| cyc_start | output | 1 | One-clock pulse on the first clock of a service cycle |
| idle | output | 1 | High for the whole of an idle service cycle |

## Verification
In read and idle cycles, the decision point and the end of the cycle fall on the same clock. The new choice must therefore go straight to the grant register, bypassing the pending register. The bench runs long sequences of back-to-back reads and idle cycles, and checks each grant and each start-to-start gap against values worked out by hand. A second overlap occurs when a hold arrives on the clock where a cycle ends, or when new requests arrive while the start is being held. The bench raises `ref_busy` and `pup_wait` across cycle ends and checks two things: the pending grant survives a request that would otherwise have won, and a hold that ends one clock before the cycle end adds no delay.

// File: rtl/rr_slot_arb.sv
module rr_slot_arb #(
  parameter int N      = 4,
  parameter int RD_LEN = 26,
  parameter int WR_LEN = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] req_wr,
  input  logic         ref_busy,
  input  logic         pup_wait,
  output logic [N-1:0] grant,
  output logic         cyc_start,
  output logic         idle
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(WR_LEN + 1);
  localparam logic [CW-1:0] DEC_AT = CW'(RD_LEN - 1);

  logic          run;
  logic [CW-1:0] cnt, len;
  logic [N-1:0]  pend_g;
  logic          pend_wr;
  logic [IW-1:0] ptr;

  logic          win_any;
  logic [IW-1:0] win_idx;
  logic [N-1:0]  win_g;
  int            j;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    j       = 0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!win_any && req[j]) begin
        win_any = 1'b1;
        win_idx = IW'(j);
      end
    end
  end

  assign win_g = win_any ? (N'(1) << win_idx) : '0;

  logic          dec, fin, hold;
  logic [N-1:0]  nxt_g;
  logic          nxt_wr;

  assign dec    = run && (cnt == DEC_AT);
  assign fin    = !run || (cnt == len - CW'(1));
  assign hold   = ref_busy || pup_wait;
  assign nxt_g  = dec ? win_g : pend_g;
  assign nxt_wr = dec ? (win_any && req_wr[win_idx]) : pend_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b1;
      cnt       <= '0;
      len       <= CW'(RD_LEN);
      pend_g    <= '0;
      pend_wr   <= 1'b0;
      ptr       <= '0;
      grant     <= '0;
      idle      <= 1'b1;
      cyc_start <= 1'b0;
    end else begin
      cyc_start <= 1'b0;
      if (dec) begin
        pend_g  <= win_g;
        pend_wr <= win_any && req_wr[win_idx];
        if (win_any) ptr <= (win_idx == IW'(N - 1)) ? '0 : win_idx + IW'(1);
      end
      if (fin) begin
        if (hold) begin
          run   <= 1'b0;
          grant <= '0;
          idle  <= 1'b0;
        end else begin
          run       <= 1'b1;
          cnt       <= '0;
          len       <= nxt_wr ? CW'(WR_LEN) : CW'(RD_LEN);
          grant     <= nxt_g;
          idle      <= ~|nxt_g;
          cyc_start <= 1'b1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rr_slot_arb_chk.sv
module rr_slot_arb_chk #(
  parameter int N      = 4,
  parameter int RD_LEN = 26
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ref_busy,
  input logic         pup_wait,
  input logic [N-1:0] grant,
  input logic         cyc_start,
  input logic         idle
);
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_cnt <= '0;
    else if (cyc_start) gap_cnt <= 16'd1;
    else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != $past(grant)) |-> (cyc_start || grant == '0)); // R2

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (grant == '0)); // R6

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (gap_cnt >= 16'(RD_LEN))); // R5

  AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !$past(ref_busy || pup_wait)); // R7
endmodule

bind rr_slot_arb rr_slot_arb_chk #(.N(N), .RD_LEN(RD_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_busy(ref_busy), .pup_wait(pup_wait),
  .grant(grant), .cyc_start(cyc_start), .idle(idle)
);

// File: tb/tb_rr_slot_arb.sv
module tb_rr_slot_arb;
  localparam int N = 4;
  localparam int RD = 26;
  localparam int WR = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, req_wr = '0;
  logic ref_busy = 1'b0, pup_wait = 1'b0;
  logic [N-1:0] grant;
  logic cyc_start, idle;

  int n_tests = 0, n_fail = 0, tick = 0, last_start = 0;
  bit done = 0;
  logic [N-1:0] q_g[$];
  int q_gap[$];
  string q_tag[$];

  always #10 clk = ~clk;

  rr_slot_arb #(.N(N), .RD_LEN(RD), .WR_LEN(WR)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .ref_busy(ref_busy), .pup_wait(pup_wait),
    .grant(grant), .cyc_start(cyc_start), .idle(idle));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_next(input logic [N-1:0] g, input int gap, input string tag);
    q_g.push_back(g);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cyc_start);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      tick++;
      if (rst_n && cyc_start) begin
        if (q_g.size() == 0) begin
          check(0, "R2 unexpected start", 1, 0);
        end else begin
          logic [N-1:0] eg;
          int egap;
          string t;
          eg = q_g.pop_front();
          egap = q_gap.pop_front();
          t = q_tag.pop_front();
          check(grant == eg, {t, " grant"}, grant, eg);
          check(idle == (eg == '0), {t, " idle"}, idle, (eg == '0));
          if (egap >= 0) check(tick - last_start == egap, {t, " gap"}, tick - last_start, egap);
        end
        last_start = tick;
      end
      if (tick > 4000) begin
        check(0, "watchdog", tick, 4000);
        finish_run();
      end
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    check(grant == '0, "R1 reset grant", grant, 0);
    check(idle == 1'b1, "R1 reset idle", idle, 1);
    check(cyc_start == 1'b0, "R1 reset start", cyc_start, 0);
    expect_next('0, -1, "R1 first idle");
    rst_n = 1'b1;

    wait_start();                                   // 1: idle
    expect_next('0, RD, "R6 idle length");
    wait_start();                                   // 2: idle
    req = 4'b1111; req_wr = '0;
    expect_next(4'b0001, RD, "R9 rr R0");
    wait_start();                                   // 3: R0 read
    expect_next(4'b0010, RD, "R9 rr R1");
    wait_start();                                   // 4: R1 read
    req_wr = 4'b1111;
    expect_next(4'b0100, RD, "R5 read len");
    wait_start();                                   // 5: R2 write
    expect_next(4'b1000, WR, "R5 write len");
    wait_start();                                   // 6: R3 write
    req = 4'b0010; req_wr = '0;
    expect_next(4'b0010, WR, "R4 pointer wrap");
    wait_start();                                   // 7: R1 read
    req = '0;
    expect_next('0, RD, "R6 idle after read");
    wait_start();                                   // 8: idle
    req = 4'b0001; req_wr = 4'b0001;
    expect_next(4'b0001, RD, "R4 search from ptr");
    wait_start();                                   // 9: R0 write
    req = '0; req_wr = '0;
    expect_next('0, WR, "R3 late request missed");
    repeat (RD) @(negedge clk);
    req = 4'b0100;
    wait_start();                                   // 10: idle
    expect_next(4'b0100, RD, "R3 late request next slot");
    wait_start();                                   // 11: R2 read
    req = '0;
    expect_next(4'b1000, RD, "R3 request at decision clock");
    repeat (RD - 1) @(negedge clk);
    req = 4'b1000;
    wait_start();                                   // 12: R3 read
    req = 4'b0010;
    ref_busy = 1'b1;
    expect_next(4'b0010, 41, "R7 refresh hold");
    repeat (30) @(negedge clk);
    req = 4'b0011;
    repeat (10) @(negedge clk);
    ref_busy = 1'b0;
    wait_start();                                   // 13: R1 read
    req = '0;
    pup_wait = 1'b1;
    expect_next('0, 31, "R8 power-up hold");
    repeat (30) @(negedge clk);
    pup_wait = 1'b0;
    wait_start();                                   // 14: idle
    pup_wait = 1'b1;
    expect_next('0, RD, "R8 short hold no delay");
    repeat (RD - 1) @(negedge clk);
    pup_wait = 1'b0;
    wait_start();                                   // 15
    repeat (2) @(negedge clk);
    check(q_g.size() == 0, "R2 all starts seen", q_g.size(), 0);
    finish_run();
  end
endmodule